// File: doc/BRIEF.md
# CAN Controller Mode-Request Handshake

This block is the mode-control part of a CAN controller. Software asks for one of two special modes, low-power sleep or configuration (init), by writing request bits. The block answers each request with its own acknowledge bit. Software polls the acknowledge bit to learn when the mode is actually in force. A request cannot be withdrawn before it has been acknowledged. Sleep is granted only when no frame is being received and every transmit buffer is empty. Init is granted at once, aborts traffic and drops bus synchronization.

While in init, the block allows writes to the configuration registers and holds the transmit pin recessive. It detects bus activity during sleep and raises a wake-up flag, and it tracks runs of recessive bits after init is left. The bus counts as synchronized after one run of 11 recessive bits, or after 128 such runs when the node is bus-off. Bit timing, message buffers and error counters belong to other blocks. These other blocks consume the `tx_force_rec` and `bus_synced` outputs.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, init_req=1, init_ack=1, cfg_wr_ok=1, tx_force_rec=1, and sleep_req, sleep_ack, wakeup_flag and bus_synced are all 0.
- R2: A write with cpu_init_wd=1 sets init_req and tx_force_rec on the clock edge that takes the write. bus_synced is 0 from the following edge on. init_ack rises one clock after init_req.
- R3: Writing cpu_init_wd=0 has no effect while init_req=1 and init_ack=0. Once init_ack=1, such a write clears init_req, and init_ack falls one clock later.
- R4: cfg_wr_ok is 1 exactly when init_req and init_ack are both 1.
- R5: sleep_ack rises one clock after an edge at which sleep_req=1, init_req=0, tx_bufs_empty=1 and rx_busy=0. It never rises while the bus is not idle.
- R6: Writing cpu_sleep_wd=0 has no effect while sleep_req=1 and sleep_ack=0.
- R7: A write with cpu_sleep_wd=1 does not set sleep_req while wakeup_flag=1.
- R8: While sleep_ack=1 and wake_en=1, a valid dominant sample (rx_valid=1, rx_bit=0) clears sleep_req and sets wakeup_flag on the same edge. sleep_ack falls one clock later. With wake_en=0 the same sample changes nothing.
- R9: wakeup_flag_clr=1 clears wakeup_flag on the next edge, unless a new wake-up occurs on that edge.
- R10: With init_req=0 and bus_off=0, bus_synced rises on the edge of the 11th consecutive valid recessive sample (rx_bit=1). Any valid dominant sample restarts the run.
- R11: With bus_off=1, bus_synced rises only on the edge that completes the 128th run of 11 recessive samples.
- R12: A write that sets init_req also clears sleep_req on the same edge. sleep_ack then falls one clock later, as init_ack rises, and the two acknowledges are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Strobe: write the request bits |
| cpu_sleep_wd | input | 1 | Written value of the sleep request |
| cpu_init_wd | input | 1 | Written value of the init request |
| wakeup_flag_clr | input | 1 | Clear the wake-up flag |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| rx_valid | input | 1 | One-cycle strobe per sampled bit |
| tx_bufs_empty | input | 1 | All transmit buffers are empty |
| rx_busy | input | 1 | A frame is being received |
| bus_off | input | 1 | Node is in bus-off state |
| wake_en | input | 1 | Allow bus activity to end sleep |
| sleep_req | output | 1 | Sleep request bit |
| init_req | output | 1 | Init request bit |
| sleep_ack | output | 1 | Sleep mode is active |
| init_ack | output | 1 | Init mode is active |
| cfg_wr_ok | output | 1 | Configuration registers may be written |
| tx_force_rec | output | 1 | Force the transmit pin recessive |
| wakeup_flag | output | 1 | Wake-up interrupt flag |
| bus_synced | output | 1 | Bus synchronization reached |

## Verification
The assertions watch the handshake rules on every cycle:
- a pending request is never withdrawn;
- sleep is never granted on a busy bus;
- the two acknowledges never overlap;
- a set wake-up flag blocks new sleep requests;
- init always clears synchronization.

Only the bench's scenarios can show the exact counts, such as the 11-sample recessive run, the 1408 samples needed when bus-off, and the restart on a dominant bit. The same holds for whole sequences, such as an init request arriving during sleep or a wake-up ignored while disabled. The random phase compares every output on every cycle against a model built from the requirements.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   localparam int unsigned RUN_LEN_DEF     = 11;
   localparam int unsigned BUSOFF_RUNS_DEF = 128;
   localparam int unsigned WAKE_SMP_DEF    = 1;

   // bus is idle when nothing is queued for transmit and no frame is arriving
   function automatic logic bus_idle(input logic tx_empty, input logic rx_active);
      return tx_empty & ~rx_active;
   endfunction

endpackage

// File: rtl/cmr_request_regs.sv
module cmr_request_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_wr,
   input  logic wd_sleep,
   input  logic wd_init,
   input  logic sleep_ack,
   input  logic init_ack,
   input  logic wake_hit,
   input  logic wake_clr,
   output logic sleep_req,
   output logic init_req,
   output logic wake_flag
);

   logic init_n, sleep_n, wflag_n;

   always_comb begin
      init_n  = init_req;
      sleep_n = sleep_req;
      if (cpu_wr) begin
         // a pending (unacknowledged) request survives a clearing write
         init_n = wd_init | (init_req & ~init_ack);
         if (wd_sleep)
            sleep_n = sleep_req | ~wake_flag;
         else
            sleep_n = sleep_req & ~sleep_ack;
      end
      if (wake_hit) sleep_n = 1'b0;
      if (init_n)   sleep_n = 1'b0;   // init has priority over sleep
      wflag_n = wake_hit | (wake_flag & ~wake_clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_req  <= 1'b1;
         sleep_req <= 1'b0;
         wake_flag <= 1'b0;
      end else begin
         init_req  <= init_n;
         sleep_req <= sleep_n;
         wake_flag <= wflag_n;
      end
   end

   assert_init_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req && !init_ack) |=> init_req);

   assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && !sleep_ack) |=> (sleep_req || init_req));

   assert_flag_blocks_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && !sleep_req) |=> !sleep_req);

   assert_wake_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_hit |=> (!sleep_req && wake_flag));

endmodule

// File: rtl/cmr_ack_stage.sv
module cmr_ack_stage
   import can_mode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic init_req,
   input  logic tx_empty,
   input  logic rx_busy,
   output logic sleep_ack,
   output logic init_ack
);

   logic idle;
   assign idle = bus_idle(tx_empty, rx_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_ack  <= 1'b1;
         sleep_ack <= 1'b0;
      end else begin
         init_ack  <= init_req;
         sleep_ack <= sleep_req & ~init_req & (sleep_ack | idle);
      end
   end

   assert_sleep_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_ack && !(tx_empty && !rx_busy)) |=> !sleep_ack);

   assert_ack_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_ack && init_ack));

   assert_init_ack_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !init_req |=> !init_ack);

endmodule

// File: rtl/cmr_wake_detect.sv
module cmr_wake_detect #(
   parameter int unsigned WAKE_SAMPLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic sample_valid,
   input  logic rx_bit,
   output logic wake_hit
);

   generate
      if (WAKE_SAMPLES < 1) begin : g_bad
         $error("WAKE_SAMPLES must be at least 1");
      end

      if (WAKE_SAMPLES == 1) begin : g_direct
         assign wake_hit = armed & sample_valid & ~rx_bit;
      end else begin : g_filtered
         localparam int unsigned CW = $clog2(WAKE_SAMPLES);
         logic [CW-1:0] dom_cnt;
         logic          dom_smp;
         assign dom_smp  = sample_valid & ~rx_bit;
         assign wake_hit = armed & dom_smp & (dom_cnt == CW'(WAKE_SAMPLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dom_cnt <= '0;
            else if (!armed || wake_hit || (sample_valid && rx_bit))
               dom_cnt <= '0;
            else if (dom_smp)
               dom_cnt <= dom_cnt + CW'(1);
         end
      end
   endgenerate

   assert_wake_only_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !wake_hit);

endmodule

// File: rtl/cmr_sync_counter.sv
module cmr_sync_counter #(
   parameter int unsigned RUN_LEN     = 11,
   parameter int unsigned BUSOFF_RUNS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic sample_valid,
   input  logic rx_bit,
   input  logic bus_off,
   output logic synced
);

   localparam int unsigned RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
   localparam int unsigned OCC_W = $clog2(BUSOFF_RUNS + 1);

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
      if (BUSOFF_RUNS < 1) begin : g_bad_occ
         $error("BUSOFF_RUNS must be at least 1");
      end
   endgenerate

   logic [RUN_W-1:0] run_cnt;
   logic [OCC_W-1:0] occ_cnt, occ_inc, occ_need;

   assign occ_inc  = occ_cnt + OCC_W'(1);
   assign occ_need = bus_off ? OCC_W'(BUSOFF_RUNS) : OCC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         occ_cnt <= '0;
         synced  <= 1'b0;
      end else if (hold) begin
         run_cnt <= '0;
         occ_cnt <= '0;
         synced  <= 1'b0;
      end else if (!synced && sample_valid) begin
         if (!rx_bit) begin
            run_cnt <= '0;
         end else if (run_cnt == RUN_W'(RUN_LEN - 1)) begin
            run_cnt <= '0;
            occ_cnt <= occ_inc;
            if (occ_inc >= occ_need) synced <= 1'b1;
         end else begin
            run_cnt <= run_cnt + RUN_W'(1);
         end
      end
   end

   assert_init_drops_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !synced);

   assert_sync_on_recessive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> $past(sample_valid && rx_bit));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int unsigned RUN_LEN      = RUN_LEN_DEF,
   parameter int unsigned BUSOFF_RUNS  = BUSOFF_RUNS_DEF,
   parameter int unsigned WAKE_SAMPLES = WAKE_SMP_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_wr,
   input  logic cpu_sleep_wd,
   input  logic cpu_init_wd,
   input  logic wakeup_flag_clr,
   input  logic rx_bit,
   input  logic rx_valid,
   input  logic tx_bufs_empty,
   input  logic rx_busy,
   input  logic bus_off,
   input  logic wake_en,
   output logic sleep_req,
   output logic init_req,
   output logic sleep_ack,
   output logic init_ack,
   output logic cfg_wr_ok,
   output logic tx_force_rec,
   output logic wakeup_flag,
   output logic bus_synced
);

   logic wake_hit;

   cmr_request_regs u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .wd_sleep  (cpu_sleep_wd),
      .wd_init   (cpu_init_wd),
      .sleep_ack (sleep_ack),
      .init_ack  (init_ack),
      .wake_hit  (wake_hit),
      .wake_clr  (wakeup_flag_clr),
      .sleep_req (sleep_req),
      .init_req  (init_req),
      .wake_flag (wakeup_flag)
   );

   cmr_ack_stage u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .init_req  (init_req),
      .tx_empty  (tx_bufs_empty),
      .rx_busy   (rx_busy),
      .sleep_ack (sleep_ack),
      .init_ack  (init_ack)
   );

   cmr_wake_detect #(.WAKE_SAMPLES(WAKE_SAMPLES)) u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .armed        (sleep_ack & wake_en),
      .sample_valid (rx_valid),
      .rx_bit       (rx_bit),
      .wake_hit     (wake_hit)
   );

   cmr_sync_counter #(.RUN_LEN(RUN_LEN), .BUSOFF_RUNS(BUSOFF_RUNS)) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .hold         (init_req),
      .sample_valid (rx_valid),
      .rx_bit       (rx_bit),
      .bus_off      (bus_off),
      .synced       (bus_synced)
   );

   assign cfg_wr_ok    = init_req & init_ack;
   assign tx_force_rec = init_req | init_ack;

   assert_cfg_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !init_req |=> !cfg_wr_ok);

endmodule

// File: tb/sim_can_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_mode_ctrl;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_wr = 0, cpu_sleep_wd = 0, cpu_init_wd = 0, wakeup_flag_clr = 0;
   logic rx_bit = 1, rx_valid = 0, tx_bufs_empty = 1, rx_busy = 0, bus_off = 0, wake_en = 0;
   logic sleep_req, init_req, sleep_ack, init_ack, cfg_wr_ok, tx_force_rec, wakeup_flag, bus_synced;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   can_mode_ctrl u0 (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic s, input logic i);
      cpu_wr = 1; cpu_sleep_wd = s; cpu_init_wd = i;
      step();
      cpu_wr = 0;
   endtask

   // reference model state, built from the requirements
   logic m_init, m_iack, m_sleep, m_sack, m_wf, m_syn;
   int   m_run, m_occ;

   task automatic model_reset();
      m_init = 1; m_iack = 1; m_sleep = 0; m_sack = 0; m_wf = 0; m_syn = 0;
      m_run = 0; m_occ = 0;
   endtask

   task automatic model_step();
      logic idle, hit, n_init, n_sleep, n_wf, n_iack, n_sack;
      idle   = tx_bufs_empty & ~rx_busy;
      hit    = m_sack & wake_en & rx_valid & ~rx_bit;
      n_init = cpu_wr ? (cpu_init_wd | (m_init & ~m_iack)) : m_init;
      n_sleep = m_sleep;
      if (cpu_wr) n_sleep = cpu_sleep_wd ? (m_sleep | ~m_wf) : (m_sleep & ~m_sack);
      if (hit)    n_sleep = 0;
      if (n_init) n_sleep = 0;
      n_wf   = hit | (m_wf & ~wakeup_flag_clr);
      n_iack = m_init;
      n_sack = m_sleep & ~m_init & (m_sack | idle);
      if (m_init) begin
         m_run = 0; m_occ = 0; m_syn = 0;
      end else if (!m_syn && rx_valid) begin
         if (!rx_bit) m_run = 0;
         else if (m_run == 10) begin
            m_run = 0; m_occ++;
            if (m_occ >= (bus_off ? 128 : 1)) m_syn = 1;
         end else m_run++;
      end
      m_init = n_init; m_sleep = n_sleep; m_wf = n_wf; m_iack = n_iack; m_sack = n_sack;
   endtask

   task automatic cmp_all();
      chk("R3 init_req",      init_req,     m_init);
      chk("R3 init_ack",      init_ack,     m_iack);
      chk("R6 sleep_req",     sleep_req,    m_sleep);
      chk("R5 sleep_ack",     sleep_ack,    m_sack);
      chk("R9 wakeup_flag",   wakeup_flag,  m_wf);
      chk("R10 bus_synced",   bus_synced,   m_syn);
      chk("R4 cfg_wr_ok",     cfg_wr_ok,    m_init & m_iack);
      chk("R2 tx_force_rec",  tx_force_rec, m_init | m_iack);
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D5EED));
      step(); step();
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 init_req", init_req, 1);   chk("R1 init_ack", init_ack, 1);
      chk("R1 cfg_wr_ok", cfg_wr_ok, 1); chk("R1 tx_force_rec", tx_force_rec, 1);
      chk("R1 sleep_req", sleep_req, 0); chk("R1 sleep_ack", sleep_ack, 0);
      chk("R1 wakeup_flag", wakeup_flag, 0); chk("R1 bus_synced", bus_synced, 0);

      // R3 leave init after ack
      wr(0, 0);
      chk("R3 init_req cleared", init_req, 0);
      chk("R3 init_ack lags", init_ack, 1);
      chk("R4 cfg closed", cfg_wr_ok, 0);
      step();
      chk("R3 init_ack falls", init_ack, 0);
      chk("R2 tx released", tx_force_rec, 0);

      // R10 run of 11 recessive, restart on dominant
      rx_valid = 1; rx_bit = 1;
      for (int k = 0; k < 10; k++) step();
      chk("R10 10 samples not synced", bus_synced, 0);
      rx_bit = 0; step(); rx_bit = 1;
      for (int k = 0; k < 10; k++) step();
      chk("R10 dominant restarted run", bus_synced, 0);
      step();
      chk("R10 synced after 11", bus_synced, 1);
      rx_valid = 0;

      // R2 / R3 enter init, withdraw blocked
      cpu_wr = 1; cpu_init_wd = 1; cpu_sleep_wd = 0; step();
      chk("R2 init_req set", init_req, 1);
      chk("R2 tx forced", tx_force_rec, 1);
      chk("R2 ack not yet", init_ack, 0);
      chk("R4 cfg not yet", cfg_wr_ok, 0);
      cpu_init_wd = 0; step(); cpu_wr = 0;
      chk("R3 withdraw ignored", init_req, 1);
      chk("R2 init_ack", init_ack, 1);
      chk("R4 cfg open", cfg_wr_ok, 1);
      chk("R2 sync dropped", bus_synced, 0);

      // R11 bus-off needs 128 runs
      bus_off = 1;
      wr(0, 0);
      rx_valid = 1; rx_bit = 1;
      for (int k = 0; k < 128 * 11 - 1; k++) step();
      chk("R11 1407 samples not synced", bus_synced, 0);
      step();
      chk("R11 synced after 128 runs", bus_synced, 1);
      rx_valid = 0; bus_off = 0;

      // R5 / R6 sleep waits for idle
      tx_bufs_empty = 0;
      wr(1, 0);
      chk("R5 sleep_req set", sleep_req, 1);
      step(); step();
      chk("R5 no ack while busy", sleep_ack, 0);
      wr(0, 0);
      chk("R6 withdraw ignored", sleep_req, 1);
      tx_bufs_empty = 1; step();
      chk("R5 ack when idle", sleep_ack, 1);

      // R8 wake-up disabled, then enabled
      wake_en = 0; rx_valid = 1; rx_bit = 0; step();
      chk("R8 disabled keeps sleep", sleep_req, 1);
      chk("R8 disabled no flag", wakeup_flag, 0);
      wake_en = 1; step(); rx_valid = 0; rx_bit = 1;
      chk("R8 wake clears sleep_req", sleep_req, 0);
      chk("R8 wake sets flag", wakeup_flag, 1);
      step();
      chk("R8 sleep_ack falls", sleep_ack, 0);

      // R7 / R9
      wr(1, 0);
      chk("R7 sleep blocked by flag", sleep_req, 0);
      wakeup_flag_clr = 1; step(); wakeup_flag_clr = 0;
      chk("R9 flag cleared", wakeup_flag, 0);
      wr(1, 0);
      chk("R7 sleep allowed after clear", sleep_req, 1);
      step();
      chk("R5 ack again", sleep_ack, 1);

      // R12 init during sleep
      wr(0, 1);
      chk("R12 init_req set", init_req, 1);
      chk("R12 sleep_req cleared", sleep_req, 0);
      step();
      chk("R12 sleep_ack dropped", sleep_ack, 0);
      chk("R12 init_ack rose", init_ack, 1);

      // random phase against the model
      rst_n = 0; wake_en = 0; step(); step(); rst_n = 1; step();
      model_reset();
      cmp_all();
      for (int n = 0; n < 4000; n++) begin
         cpu_wr          = ($urandom % 4) == 0;
         cpu_sleep_wd    = $urandom % 2;
         cpu_init_wd     = ($urandom % 3) == 0;
         wakeup_flag_clr = ($urandom % 8) == 0;
         rx_valid        = $urandom % 2;
         rx_bit          = ($urandom % 10) != 0;
         tx_bufs_empty   = ($urandom % 4) != 0;
         rx_busy         = ($urandom % 4) == 0;
         bus_off         = ($urandom % 50) == 0;
         wake_en         = $urandom % 2;
         model_step();
         step();
         cmp_all();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule